// File: doc/BRIEF.md
# Burst Address Sequencer (linear / interleaved)

This block generates addresses for a memory that serves up to four beats from one start address. A load cycle captures the start address. Each later advance cycle steps the two lowest address bits to the next beat. The upper bits stay as they were captured. A mode input picks between two orders. Linear order counts upward and wraps modulo four. Interleaved order XORs the captured start bits with a beat count.

Each cycle has one control input. When it is low, the block loads a new start. When it is high, the block advances the beat. A stall input freezes every register. The mode input is not registered. It selects the order combinationally from the held start and beat, so changing it re-maps the current beat at once. Until the first load after reset, the output address simply follows the input address.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the beat count `beat_out` is 0. Until the first load, `addr_out` equals `addr_in` in every cycle.
- R2: A clock edge with `stall`=0 and `seq_advance`=0 captures `addr_in`. From the next cycle, `addr_out` equals the captured address and `beat_out` is 0.
- R3: A clock edge with `stall`=0 and `seq_advance`=1 raises `beat_out` by one, modulo 4 (3 is followed by 0).
- R4: With `mode_ilv`=0 (linear), the low two bits of `addr_out` after a load are (start + beat) mod 4. For example, start 1 gives 1,2,3,0.
- R5: With `mode_ilv`=1 (interleaved), the low two bits of `addr_out` after a load are start XOR beat. For example, start 1 gives 1,0,3,2.
- R6: During advance cycles, the bits of `addr_out` above bit 1 keep the captured value, whatever `addr_in` does.
- R7: While `stall`=1, `beat_out` and the captured address hold. Any load or advance request is ignored.
- R8: The order follows the present value of `mode_ilv`. Switching it in the middle of a burst re-maps the current beat in the same cycle, with no clock edge needed.
- R9: After four advances from a load, the low bits return to the start value in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall | input | 1 | 1 freezes the sequencer |
| seq_advance | input | 1 | 0 loads a start address, 1 advances the beat |
| mode_ilv | input | 1 | 0 linear order, 1 interleaved order |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_out | output | 2 | Beat count since the last load |

## Verification
The order properties compare consecutive advance cycles. They assume `mode_ilv` does not change across the pair, and they only apply after a load has been seen. The stall property on `addr_out` also assumes the mode holds. The stimulus keeps the mode steady within each checked burst. It changes the mode only in one deliberate step, which the bench model covers but the nested implications skip. Stall is held high until the internal reset release has passed, so the first real load sees the synchronised reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BURST_LOW_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bseq_state.sv
module bseq_state #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LOW_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    seq_advance,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic                    loaded,
  output logic [LOW_W-1:0]        start,
  output logic [ADDR_W-LOW_W-1:0] upper,
  output logic [LOW_W-1:0]        beat
);
  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic              loaded_q, loaded_d;
  logic [LOW_W-1:0]  start_q,  start_d;
  logic [UP_W-1:0]   upper_q,  upper_d;
  logic [LOW_W-1:0]  beat_q,   beat_d;

  always_comb begin
    loaded_d = loaded_q;
    start_d  = start_q;
    upper_d  = upper_q;
    beat_d   = beat_q;
    if (!stall) begin
      if (!seq_advance) begin
        loaded_d = 1'b1;
        start_d  = addr_in[LOW_W-1:0];
        upper_d  = addr_in[ADDR_W-1:LOW_W];
        beat_d   = '0;
      end else begin
        beat_d   = beat_q + LOW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      start_q  <= '0;
      upper_q  <= '0;
      beat_q   <= '0;
    end else begin
      loaded_q <= loaded_d;
      start_q  <= start_d;
      upper_q  <= upper_d;
      beat_q   <= beat_d;
    end
  end

  assign loaded = loaded_q;
  assign start  = start_q;
  assign upper  = upper_q;
  assign beat   = beat_q;
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import burst_seq_pkg::*;
#(
  parameter int unsigned LOW_W       = 2,
  parameter bit          SUPPORT_XOR = 1'b1
) (
  input  burst_order_e     order,
  input  logic [LOW_W-1:0] start,
  input  logic [LOW_W-1:0] beat,
  output logic [LOW_W-1:0] low
);
  logic [LOW_W-1:0] lin_low;

  assign lin_low = start + beat;

  generate
    if (SUPPORT_XOR) begin : g_both
      logic [LOW_W-1:0] xor_low;
      assign xor_low = start ^ beat;
      always_comb begin
        unique case (order)
          ORD_XOR: low = xor_low;
          default: low = lin_low;
        endcase
      end
    end else begin : g_linear_only
      logic unused_order;
      assign unused_order = order;
      assign low = lin_low;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned LOW_W       = BURST_LOW_W,
  parameter bit          SUPPORT_XOR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              seq_advance,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LOW_W-1:0]  beat_out
);
  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic             rst_sync_n;
  logic             loaded;
  logic [LOW_W-1:0] start;
  logic [UP_W-1:0]  upper;
  logic [LOW_W-1:0] beat;
  logic [LOW_W-1:0] low;
  burst_order_e     order;

  assign order = mode_ilv ? ORD_XOR : ORD_LINEAR;

  bseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bseq_state #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .stall       (stall),
    .seq_advance (seq_advance),
    .addr_in     (addr_in),
    .loaded      (loaded),
    .start       (start),
    .upper       (upper),
    .beat        (beat)
  );

  bseq_order #(.LOW_W(LOW_W), .SUPPORT_XOR(SUPPORT_XOR)) u_order (
    .order (order),
    .start (start),
    .beat  (beat),
    .low   (low)
  );

  assign addr_out = loaded ? {upper, low} : addr_in;
  assign beat_out = beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned LOW_W       = 2,
  parameter bit          SUPPORT_XOR = 1'b1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              stall,
  input logic              seq_advance,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [LOW_W-1:0]  beat_out
);
  logic seen_load;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)                    seen_load <= 1'b0;
    else if (!stall && !seq_advance) seen_load <= 1'b1;
  end

  // R1
  pass_before_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !seen_load |-> addr_out == addr_in);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!stall && !seq_advance) |=> (beat_out == '0 && addr_out == $past(addr_in)));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!stall && seq_advance) |=> beat_out == $past(beat_out) + LOW_W'(1));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_load && !stall && seq_advance && !mode_ilv) |=>
      (!mode_ilv |-> addr_out[LOW_W-1:0] == $past(addr_out[LOW_W-1:0]) + LOW_W'(1)));

  generate
    if (SUPPORT_XOR) begin : g_xor_chk
      // R5
      xor_start_kept_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (seen_load && !stall && seq_advance && mode_ilv) |=>
          (mode_ilv |-> (addr_out[LOW_W-1:0] ^ beat_out) ==
                        $past(addr_out[LOW_W-1:0] ^ beat_out)));
    end
  endgenerate

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_load && !stall && seq_advance) |=> $stable(addr_out[ADDR_W-1:LOW_W]));

  // R7
  stall_beat_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    stall |=> $stable(beat_out));

  // R7
  stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_load && stall) |=> ($stable(mode_ilv) |-> $stable(addr_out)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .SUPPORT_XOR(SUPPORT_XOR)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .stall       (stall),
  .seq_advance (seq_advance),
  .mode_ilv    (mode_ilv),
  .addr_in     (addr_in),
  .addr_out    (addr_out),
  .beat_out    (beat_out)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall;
  logic          seq_advance;
  logic          mode_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // behavioural reference state
  bit            m_loaded;
  logic [1:0]    m_start;
  logic [AW-3:0] m_upper;
  int            m_beat;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .seq_advance(seq_advance),
    .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out), .beat_out(beat_out)
  );

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (!m_loaded) return addr_in;
    if (mode_ilv) lo = int'(m_start) ^ m_beat;
    else          lo = (int'(m_start) + m_beat) % 4;
    return {m_upper, 2'(lo)};
  endfunction

  task automatic compare(input string tag);
    logic [AW-1:0] ea;
    ea = model_addr();
    checks++;
    if (addr_out !== ea) begin
      errors++;
      $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, ea);
    end
    checks++;
    if (beat_out !== 2'(m_beat)) begin
      errors++;
      $display("FAIL %s beat_out actual=%0d expected=%0d", tag, beat_out, m_beat);
    end
  endtask

  task automatic cyc(input logic s, input logic a, input logic m,
                     input logic [AW-1:0] ad, input string tag);
    @(negedge clk);
    stall = s; seq_advance = a; mode_ilv = m; addr_in = ad;
    #1 compare(tag);
    @(posedge clk);
    if (rst_n && !s) begin
      if (!a) begin
        m_loaded = 1; m_start = ad[1:0]; m_upper = ad[AW-1:2]; m_beat = 0;
      end else begin
        m_beat = (m_beat + 1) % 4;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_loaded = 0; m_start = 0; m_upper = 0; m_beat = 0;
    rst_n = 0; stall = 1; seq_advance = 1; mode_ilv = 0; addr_in = '0;
    // R1: reset state, pass-through
    cyc(1, 1, 0, 18'h12345, "R1");
    cyc(1, 0, 1, 18'h3abcd, "R1");
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 18'(i * 77), "R1");
    // R1: still passing through before any load, while advancing
    cyc(0, 1, 0, 18'h00f0f, "R1");
    cyc(0, 1, 0, 18'h2aaa6, "R1");
    // R2/R4/R9: linear burst from start 1
    cyc(0, 0, 0, 18'h15551, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 18'h15551, "R4");
    cyc(0, 1, 0, 18'h15551, "R9");
    // R5/R9: interleaved burst from start 1, addr_in wandering (R6)
    cyc(0, 0, 1, 18'h2c3a1, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 18'(i * 4099), "R5");
    cyc(0, 1, 1, 18'h00000, "R9");
    // R6: upper bits stay put while addr_in changes
    cyc(0, 0, 0, 18'h3fffe, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 18'(i * 12345), "R6");
    // R7: stall ignores load and advance requests
    cyc(0, 0, 1, 18'h01232, "R2");
    cyc(0, 1, 1, 18'h01232, "R5");
    cyc(1, 0, 1, 18'h3ffff, "R7");
    cyc(1, 1, 1, 18'h00001, "R7");
    cyc(1, 0, 1, 18'h2aaaa, "R7");
    cyc(0, 1, 1, 18'h2aaaa, "R7");
    // R8: mode switch mid-burst re-maps immediately
    cyc(0, 0, 0, 18'h00102, "R2");
    cyc(0, 1, 0, 18'h00102, "R8");
    cyc(0, 1, 1, 18'h00102, "R8");
    cyc(1, 1, 0, 18'h00102, "R8");
    cyc(1, 1, 1, 18'h00102, "R8");
    // R4/R5/R9: every start in both orders, full wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 1'(m), 18'(s + 256 * (s + 1)), "R2");
        for (int b = 0; b < 4; b++) cyc(0, 1, 1'(m), 18'h0, m ? "R5" : "R4");
        cyc(0, 1, 1'(m), 18'h0, "R9");
      end
    // R1: reset mid-burst clears back to pass-through
    @(negedge clk); rst_n = 0;
    m_loaded = 0; m_beat = 0; m_start = 0; m_upper = 0;
    cyc(1, 1, 0, 18'h0beef, "R1");
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 18'(i + 5), "R1");
    cyc(0, 1, 0, 18'h1234f, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule